// File: doc/BRIEF.md
# Second-Order Noise-Shaping Requantizer

This block lies in the transmit datapath of a line transmitter, between an oversampling interpolator and a multibit DAC. Each oversampled two's-complement sample of 15 bits is reduced to a 7-bit sign-magnitude code: one sign bit and six magnitude bits. The eight discarded low bits are not simply thrown away. The block keeps the requantization error and feeds it back so that the error spectrum takes a second-order highpass shape, (1 − z⁻¹)². The noise therefore moves out of the signal band, and the analog reconstruction filter that follows removes it.

Each valid input cycle forms a shaped value s[n] = x[n] + 2·e[n−1] − e[n−2]. That value is truncated toward negative infinity to a signed integer q. The integer q is limited to ±63 and then converted to sign-magnitude. The new error e[n] = s[n] − 256·q is limited to the nine-bit signed range and stored in place of the oldest error term. The output register is loaded one clock after its input. Its rate depends only on the input strobe, so the block keeps up with any DAC update rate up to and beyond 1.1 MHz.

Top module: `nsq_requant`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `out_code` and both stored error terms. The first sample after reset therefore yields exactly floor(x/256); for example, x = −1 yields sign 1 and magnitude 1.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, which is a fixed latency of one clock.
- R3: A code with sign 1 and magnitude 0 is never emitted. A zero result is always sent with sign 0.
- R4: When the truncated shaped value is above +63 the code is +63 (sign 0, magnitude 63). When it is below −63 the code is −63 (sign 1, magnitude 63).
- R5: Truncation discards the low 8 bits of the shaped value toward negative infinity. For example, right after reset x = 300 gives +1 and x = −300 gives −2.
- R6: The shaped value is x[n] + 2·e[n−1] − e[n−2], where e[n] = s[n] − 256·q[n] is limited to the range −256..255.
- R7: The stored error terms change only in cycles with `in_valid` high. Idle cycles between samples leave the output sequence identical to the sequence obtained with no gaps.
- R8: `out_code[6]` is the sign (1 = negative) and `out_code[5:0]` is the magnitude |q|.
- R9: `out_code` holds its last value during cycles in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a cycle that carries a new sample |
| in_sample | input | 15 | Two's-complement oversampled transmit sample |
| out_valid | output | 1 | Marks a cycle with a new DAC code |
| out_code | output | 7 | Sign-magnitude DAC code: bit 6 is the sign, bits 5:0 are the magnitude |

## Verification
The assertions check on every cycle:
- the one-clock valid latency;
- the absence of negative zero;
- the holding of the code while idle;
- the freezing and shifting of the two error terms;
- the cleared state after reset.

The arithmetic cannot be shown by the assertions. This covers the floor truncation, the exact error recurrence, the clamping of the error term and the saturation of long full-scale runs. The bench's scenarios show it by comparing every output with an independent integer model of the loop. The same comparisons, run with idle gaps and mid-stream resets, show that gaps do not disturb the shaped sequence.

// File: rtl/nsq_pkg.sv
package nsq_pkg;
  localparam int unsigned NSQ_IN_W  = 15;
  localparam int unsigned NSQ_MAG_W = 6;

  typedef enum logic [1:0] {
    QR_PASS    = 2'd0,
    QR_CLIP_HI = 2'd1,
    QR_CLIP_LO = 2'd2
  } qregion_e;
endpackage

// File: rtl/nsq_shaper.sv
module nsq_shaper #(
  parameter int unsigned IN_W  = 15,
  parameter int unsigned ERR_W = 9,
  parameter int unsigned SUM_W = 17
) (
  input  logic [IN_W-1:0]  sample,
  input  logic [ERR_W-1:0] err_z1,
  input  logic [ERR_W-1:0] err_z2,
  output logic [SUM_W-1:0] shaped
);
  localparam int unsigned XEXT  = SUM_W - IN_W;
  localparam int unsigned E1EXT = SUM_W - ERR_W - 1;
  localparam int unsigned E2EXT = SUM_W - ERR_W;

  logic [SUM_W-1:0] x_ext;
  logic [SUM_W-1:0] e1_dbl;
  logic [SUM_W-1:0] e2_ext;

  always_comb begin
    x_ext  = {{XEXT{sample[IN_W-1]}}, sample};
    e1_dbl = {{E1EXT{err_z1[ERR_W-1]}}, err_z1, 1'b0};
    e2_ext = {{E2EXT{err_z2[ERR_W-1]}}, err_z2};
    shaped = x_ext + e1_dbl - e2_ext;
  end
endmodule

// File: rtl/nsq_quant.sv
module nsq_quant
  import nsq_pkg::*;
#(
  parameter int unsigned SUM_W = 17,
  parameter int unsigned DROP  = 8,
  parameter int unsigned MAG_W = 6,
  parameter int unsigned ERR_W = 9
) (
  input  logic [SUM_W-1:0] shaped,
  output logic             q_sign,
  output logic [MAG_W-1:0] q_mag,
  output logic [ERR_W-1:0] err_next
);
  localparam int unsigned Q_W = SUM_W - DROP;
  localparam logic signed [Q_W-1:0]   QHI = Q_W'((2 ** MAG_W) - 1);
  localparam logic signed [Q_W-1:0]   QLO = Q_W'(-((2 ** MAG_W) - 1));
  localparam logic signed [SUM_W-1:0] EHI = SUM_W'((2 ** DROP) - 1);
  localparam logic signed [SUM_W-1:0] ELO = SUM_W'(-(2 ** DROP));

  logic signed [Q_W-1:0]   q_floor;
  logic signed [Q_W-1:0]   q_sat;
  logic signed [Q_W-1:0]   q_abs;
  logic signed [SUM_W-1:0] rescaled;
  logic signed [SUM_W-1:0] diff;
  qregion_e                region;

  // Dropping the low bits of a two's-complement word floors toward -inf.
  assign q_floor = $signed(shaped[SUM_W-1:DROP]);

  always_comb begin
    if (q_floor > QHI)      region = QR_CLIP_HI;
    else if (q_floor < QLO) region = QR_CLIP_LO;
    else                    region = QR_PASS;

    case (region)
      QR_CLIP_HI: q_sat = QHI;
      QR_CLIP_LO: q_sat = QLO;
      default:    q_sat = q_floor;
    endcase

    q_sign = q_sat[Q_W-1];
    q_abs  = q_sign ? -q_sat : q_sat;
    q_mag  = q_abs[MAG_W-1:0];
  end

  always_comb begin
    rescaled = {q_sat, {DROP{1'b0}}};
    diff     = $signed(shaped) - rescaled;
    if (diff > EHI)      err_next = EHI[ERR_W-1:0];
    else if (diff < ELO) err_next = ELO[ERR_W-1:0];
    else                 err_next = diff[ERR_W-1:0];
  end
endmodule

// File: rtl/nsq_errfb.sv
module nsq_errfb #(
  parameter int unsigned ERR_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [ERR_W-1:0] err_in,
  output logic [ERR_W-1:0] err_z1,
  output logic [ERR_W-1:0] err_z2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_z1 <= '0;
      err_z2 <= '0;
    end else if (adv) begin
      err_z2 <= err_z1;
      err_z1 <= err_in;
    end
  end
endmodule

// File: rtl/nsq_requant.sv
module nsq_requant
  import nsq_pkg::*;
#(
  parameter int unsigned IN_W  = NSQ_IN_W,
  parameter int unsigned MAG_W = NSQ_MAG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [IN_W-1:0]    in_sample,
  output logic               out_valid,
  output logic [MAG_W:0]     out_code
);
  localparam int unsigned CODE_W = MAG_W + 1;
  localparam int unsigned DROP   = IN_W - CODE_W;
  localparam int unsigned ERR_W  = DROP + 1;
  localparam int unsigned SUM_W  = IN_W + 2;

  logic [ERR_W-1:0] err_z1;
  logic [ERR_W-1:0] err_z2;
  logic [ERR_W-1:0] err_next;
  logic [SUM_W-1:0] shaped;
  logic             q_sign;
  logic [MAG_W-1:0] q_mag;

  nsq_shaper #(.IN_W(IN_W), .ERR_W(ERR_W), .SUM_W(SUM_W)) u_shape (
    .sample (in_sample),
    .err_z1 (err_z1),
    .err_z2 (err_z2),
    .shaped (shaped)
  );

  nsq_quant #(.SUM_W(SUM_W), .DROP(DROP), .MAG_W(MAG_W), .ERR_W(ERR_W)) u_quant (
    .shaped   (shaped),
    .q_sign   (q_sign),
    .q_mag    (q_mag),
    .err_next (err_next)
  );

  nsq_errfb #(.ERR_W(ERR_W)) u_fb (
    .clk    (clk),
    .rst    (rst),
    .adv    (in_valid),
    .err_in (err_next),
    .err_z1 (err_z1),
    .err_z2 (err_z2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_code <= {q_sign, q_mag};
    end
  end
endmodule

// File: rtl/nsq_requant_chk.sv
module nsq_requant_chk #(
  parameter int unsigned MAG_W = 6,
  parameter int unsigned ERR_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [MAG_W:0]   out_code,
  input logic [ERR_W-1:0] err1,
  input logic [ERR_W-1:0] err2
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_code == '0 && err1 == '0 && err2 == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r3_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_code[MAG_W] && out_code[MAG_W-1:0] == '0));

  a_r7_err_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(err1) && $stable(err2)));

  a_r7_err_shift: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (err2 == $past(err1)));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_code));
endmodule

bind nsq_requant nsq_requant_chk #(.MAG_W(MAG_W), .ERR_W(ERR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_code  (out_code),
  .err1      (err_z1),
  .err2      (err_z2)
);

// File: tb/sim_nsq_requant.sv
module sim_nsq_requant;
  localparam int IN_W  = 15;
  localparam int MAG_W = 6;
  localparam int QMAX  = 63;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [IN_W-1:0]  in_sample = '0;
  logic             out_valid;
  logic [MAG_W:0]   out_code;

  int checks = 0;
  int fails  = 0;
  int m1 = 0;
  int m2 = 0;
  string tag = "R1";
  logic [MAG_W:0] exp_q[$];
  string          tag_q[$];
  logic [MAG_W:0] last_code = '0;
  logic [15:0]    lfsr = 16'hACE1;

  always #10 clk = ~clk;

  nsq_requant u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_code(out_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  function automatic logic [MAG_W:0] model_step(input int x);
    int v, q, e;
    v = x + 2 * m1 - m2;
    q = v >>> 8;
    if (q > QMAX) q = QMAX;
    if (q < -QMAX) q = -QMAX;
    e = v - q * 256;
    if (e > 255) e = 255;
    if (e < -256) e = -256;
    m2 = m1;
    m1 = e;
    return (q < 0) ? {1'b1, 6'(-q)} : {1'b0, 6'(q)};
  endfunction

  task automatic drive(input int x, input int idle_after);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = 15'(x);
    exp_q.push_back(model_step(x));
    tag_q.push_back(tag);
    for (int i = 0; i < idle_after; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    idle(2);
    rst = 1'b1;
    idle(3);
    m1 = 0;
    m2 = 0;
    last_code = '0;
    rst = 1'b0;
  endtask

  // Monitor: pop expected codes as the design produces them
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", 1, 0);
        end else begin
          logic [MAG_W:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_code == e, t, int'(out_code), int'(e));
        end
        check(!(out_code[MAG_W] && out_code[MAG_W-1:0] == 0), "R3", int'(out_code), 0);
        last_code = out_code;
      end else begin
        check(out_code == last_code, "R9", int'(out_code), int'(last_code));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    check(out_valid == 1'b0, "R1", int'(out_valid), 0);
    check(out_code == '0, "R1", int'(out_code), 0);
    tag = "R1";
    drive(-1, 2);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    check(last_code == 7'b1000001, "R1", int'(last_code), 7'b1000001);

    // R5: floor truncation from a cleared state
    do_reset();
    tag = "R5";
    drive(300, 2);
    check(last_code == 7'd1, "R5", int'(last_code), 1);
    do_reset();
    drive(-300, 2);
    check(last_code == 7'b1000010, "R5", int'(last_code), 7'b1000010);
    drive(255, 0);
    drive(0, 0);
    drive(-256, 0);

    // R6: feedback recurrence under constant and stepped inputs
    do_reset();
    tag = "R6";
    for (int i = 0; i < 40; i++) drive(100, 0);
    for (int i = 0; i < 40; i++) drive(-777, 0);
    for (int i = 0; i < 30; i++) drive((i % 2) ? 5000 : -5000, 0);

    // R4: saturation at both full-scale ends
    do_reset();
    tag = "R4";
    for (int i = 0; i < 20; i++) drive(16383, 0);
    idle(2);
    check(last_code == 7'd63, "R4", int'(last_code), 63);
    for (int i = 0; i < 20; i++) drive(-16384, 0);
    idle(2);
    check(last_code == 7'b1111111, "R4", int'(last_code), 7'b1111111);
    for (int i = 0; i < 10; i++) drive(16200, 0);

    // R7: idle gaps must not disturb the sequence
    do_reset();
    tag = "R7";
    for (int i = 0; i < 60; i++) drive((i * 523) % 30000 - 15000, i % 4);

    // R8: pseudo-random full-range samples, sign-magnitude layout
    tag = "R8";
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(int'($signed(lfsr[14:0])), (lfsr[3:0] == 0) ? 1 : 0);
    end

    // R1: reset mid-stream clears stored error
    tag = "R1";
    drive(12345, 0);
    drive(-4321, 0);
    do_reset();
    drive(-129, 2);
    check(last_code == 7'b1000001, "R1", int'(last_code), 7'b1000001);

    idle(4);
    check(exp_q.size() == 0, "R2", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule